// File: doc/BRIEF.md
# Periodic Rate and Divider Generator

This block turns a reference-clock enable into three timing outputs: a one-cycle periodic tick at a selectable rate, a square-wave level that follows that rate, and the one-second tick that drives a time-of-day counter. The reference is a clock-enable pulse on the system clock. A prescaler first reduces the selected reference to a common base rate of 32768 base ticks per second. A binary divider chain then counts base ticks, and the periodic rate is taken from one of its taps.

An 8-bit control byte configures the block. The three-bit divider field in bits 6:4 either selects the reference frequency or holds the whole divider in reset. The four-bit rate field in bits 3:0 selects one of fifteen logarithmically spaced rates, or none. A separate input enables the square wave. Software holds the divider in reset while it changes the reference selection. Releasing the reset starts a full second from zero.

Top module: `rate_div_gen`

## Requirements
- R1: The divider field is control bits 6:4. Code 0 selects the fast reference and makes one base tick every 128 reference pulses. Code 1 selects the middle reference, with one base tick every 32 pulses. Code 2 selects the slow reference, where every pulse is a base tick.
- R2: Divider codes 3 through 7 hold the divider in reset. From the next cycle the periodic tick, the square wave and the one-second tick are all low, and the prescaler and the chain restart from zero when the hold ends.
- R3: The rate field is control bits 3:0. Rate code 0 produces no periodic tick.
- R4: For rate code n from 1 to 15, the periodic tick pulses for one cycle after every base tick whose count since release is a multiple of 2^(n-1). Code 1 gives a tick on every base tick and code 15 gives one tick per 16384 base ticks.
- R5: While the square-wave enable is 1, the rate is nonzero and the divider is not held, the square wave inverts in the same cycle as each periodic tick. Otherwise it is low, so it always starts low.
- R6: A change of rate code leaves the chain running. The new code applies from the next base tick, and the square wave changes level only together with a periodic tick or when it is forced low.
- R7: The one-second tick pulses for one cycle after every 32768th base tick. The first pulse follows the 32768th base tick after the hold is released.
- R8: Cycles with the reference enable low advance nothing. Only reference pulses count towards base ticks.
- R9: Control bit 7 has no effect on any output.
- R10: A synchronous active-high reset drives all three outputs low and clears the prescaler and the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | One-cycle pulse per reference-clock period |
| ctrl_i | input | 8 | Control byte: bits 6:4 divider field, bits 3:0 rate field, bit 7 unused |
| sqw_en | input | 1 | Square-wave enable |
| periodic_tick | output | 1 | One-cycle periodic pulse at the selected rate |
| sq_wave | output | 1 | Square-wave level |
| sec_tick | output | 1 | One-cycle pulse once per second of base time |

## Verification
The hardest cases to reach are the slowest taps and the one-second tick, because each needs tens of thousands of base ticks from a known release point. The bench keeps the slow reference, where every enable pulse is a base tick, with the enable high on every cycle. It then sweeps all fifteen rate codes in one continuous run without a hold, so every code change happens mid-count. The first one-second tick arrives during this sweep, and a second release later checks it again. The fast and middle references use shorter runs, and the middle one has a sparse enable pattern. A cycle-level arithmetic model built from the base-tick count predicts every output.

// File: rtl/rdg_pkg.sv
package rdg_pkg;

    localparam int CTRL_W   = 8;
    localparam int DIV_LSB  = 4;
    localparam int DIV_W    = 3;
    localparam int RATE_W   = 4;

    typedef enum logic [1:0] {
        REF_FAST = 2'd0,
        REF_MID  = 2'd1,
        REF_SLOW = 2'd2,
        REF_HOLD = 2'd3
    } ref_mode_e;

    typedef struct packed {
        logic              spare;
        logic [DIV_W-1:0]  div;
        logic [RATE_W-1:0] rate;
    } ctrl_t;

    // Divider field to reference mode; every undefined code freezes the divider.
    function automatic ref_mode_e decode_div(input logic [DIV_W-1:0] d);
        case (d)
            3'd0:    return REF_FAST;
            3'd1:    return REF_MID;
            3'd2:    return REF_SLOW;
            default: return REF_HOLD;
        endcase
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rdg_prescale.sv
module rdg_prescale
    import rdg_pkg::*;
#(
    parameter int FAST_LOG2 = 7,
    parameter int MID_LOG2  = 5,
    parameter int SLOW_LOG2 = 0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      hold,
    input  ref_mode_e mode,
    input  logic      ref_en,
    output logic      base_tick
);

    localparam int MAXL  = max_int(max_int(FAST_LOG2, MID_LOG2), SLOW_LOG2);
    localparam int PRE_W = max_int(MAXL, 1);
    localparam logic [PRE_W-1:0] FAST_M1 = PRE_W'((1 << FAST_LOG2) - 1);
    localparam logic [PRE_W-1:0] MID_M1  = PRE_W'((1 << MID_LOG2) - 1);
    localparam logic [PRE_W-1:0] SLOW_M1 = PRE_W'((1 << SLOW_LOG2) - 1);

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] limit_m1;

    always_comb begin
        case (mode)
            REF_FAST: limit_m1 = FAST_M1;
            REF_MID:  limit_m1 = MID_M1;
            default:  limit_m1 = SLOW_M1;
        endcase
    end

    assign base_tick = ref_en & ~hold & (pre_cnt >= limit_m1);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            pre_cnt <= '0;
        end else if (ref_en) begin
            pre_cnt <= base_tick ? '0 : pre_cnt + 1'b1;
        end
    end

    AST_PRE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!ref_en && !hold) |=> $stable(pre_cnt)) else $error("prescaler moved without a pulse"); // R8

endmodule

// File: rtl/rdg_chain.sv
module rdg_chain #(
    parameter int SEC_LOG2 = 15
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hold,
    input  logic                base_tick,
    output logic [SEC_LOG2-1:0] cnt,
    output logic                sec_tick
);

    logic wrap;
    assign wrap = base_tick & (&cnt);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt      <= '0;
            sec_tick <= 1'b0;
        end else begin
            sec_tick <= wrap;
            if (base_tick) cnt <= cnt + 1'b1;
        end
    end

    AST_SEC_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
        sec_tick |-> (cnt == '0)) else $error("second tick away from chain wrap"); // R7

endmodule

// File: rtl/rdg_tap.sv
module rdg_tap #(
    parameter int CHAIN_W = 15,
    parameter int RATE_W  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hold,
    input  logic               base_tick,
    input  logic [CHAIN_W-1:0] cnt,
    input  logic [RATE_W-1:0]  rate,
    input  logic               sqw_en,
    output logic               tick,
    output logic               sq
);

    localparam int NCODES = 1 << RATE_W;

    logic [NCODES-1:0] tap_hit;
    logic              tick_c;
    logic              quiet;

    assign tap_hit[0] = 1'b0;
    assign tap_hit[1] = 1'b1;

    // Code n fires when the low n-1 chain bits are all ones.
    for (genvar n = 2; n < NCODES; n++) begin : g_tap
        localparam int HI = (n - 2 < CHAIN_W) ? (n - 2) : (CHAIN_W - 1);
        assign tap_hit[n] = &cnt[HI:0];
    end

    assign tick_c = base_tick & ~hold & tap_hit[rate];
    assign quiet  = hold | ~sqw_en | (rate == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            tick <= 1'b0;
            sq   <= 1'b0;
        end else begin
            tick <= tick_c;
            if (quiet)       sq <= 1'b0;
            else if (tick_c) sq <= ~sq;
        end
    end

    AST_RATE_NONE: assert property (@(posedge clk) disable iff (rst)
        (rate == '0) |=> !tick) else $error("tick with rate none"); // R3

    AST_SQ_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !$stable(sq) |-> (tick || !sq)) else $error("square wave moved off a tick"); // R6

    AST_SQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        !sqw_en |=> !sq) else $error("square wave active while disabled"); // R5

endmodule

// File: rtl/rate_div_gen.sv
module rate_div_gen
    import rdg_pkg::*;
#(
    parameter int FAST_LOG2 = 7,
    parameter int MID_LOG2  = 5,
    parameter int SLOW_LOG2 = 0,
    parameter int SEC_LOG2  = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_en,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic              sqw_en,
    output logic              periodic_tick,
    output logic              sq_wave,
    output logic              sec_tick
);

    ctrl_t               ctrl;
    ref_mode_e           mode;
    logic                hold;
    logic                base_tick;
    logic [SEC_LOG2-1:0] chain_cnt;
    logic                ctrl_unused;

    assign ctrl        = ctrl_t'(ctrl_i);
    assign ctrl_unused = ctrl.spare;
    assign mode        = decode_div(ctrl.div);
    assign hold        = (mode == REF_HOLD);

    rdg_prescale #(
        .FAST_LOG2 (FAST_LOG2),
        .MID_LOG2  (MID_LOG2),
        .SLOW_LOG2 (SLOW_LOG2)
    ) u_pre (
        .clk       (clk),
        .rst       (rst),
        .hold      (hold),
        .mode      (mode),
        .ref_en    (ref_en),
        .base_tick (base_tick)
    );

    rdg_chain #(
        .SEC_LOG2 (SEC_LOG2)
    ) u_chain (
        .clk       (clk),
        .rst       (rst),
        .hold      (hold),
        .base_tick (base_tick),
        .cnt       (chain_cnt),
        .sec_tick  (sec_tick)
    );

    rdg_tap #(
        .CHAIN_W (SEC_LOG2),
        .RATE_W  (RATE_W)
    ) u_tap (
        .clk       (clk),
        .rst       (rst),
        .hold      (hold),
        .base_tick (base_tick),
        .cnt       (chain_cnt),
        .rate      (ctrl.rate),
        .sqw_en    (sqw_en),
        .tick      (periodic_tick),
        .sq        (sq_wave)
    );

    AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (rst)
        hold |=> (!periodic_tick && !sq_wave && !sec_tick)) else $error("output active in hold"); // R2

    AST_RESET_LOW: assert property (@(posedge clk)
        rst |=> (!periodic_tick && !sq_wave && !sec_tick)) else $error("output active after reset"); // R10

endmodule

// File: tb/rate_div_gen_tb_top.sv
`timescale 1ns/1ps
module rate_div_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       ref_en;
    logic [7:0] ctrl;
    logic       sqw_en;
    logic       periodic_tick;
    logic       sq_wave;
    logic       sec_tick;

    int    checks = 0;
    int    errors = 0;
    int    r_cnt  = 0;
    int    b_cnt  = 0;
    logic  e_sq   = 1'b0;
    string tag    = "R10";
    bit    done   = 1'b0;

    always #2.5 clk = ~clk;

    rate_div_gen dut_i (
        .clk           (clk),
        .rst           (rst),
        .ref_en        (ref_en),
        .ctrl_i        (ctrl),
        .sqw_en        (sqw_en),
        .periodic_tick (periodic_tick),
        .sq_wave       (sq_wave),
        .sec_tick      (sec_tick)
    );

    task automatic chk(input string nm, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            if (errors < 20)
                $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, nm, act, exp, $time);
        end
    endtask

    // One clock: predict from the inputs seen at the edge, compare after it.
    task automatic step();
        int   ratio;
        int   rate;
        int   div;
        logic hold;
        logic base;
        logic e_tick;
        logic e_sec;
        @(posedge clk);
        div   = int'(ctrl[6:4]);
        rate  = int'(ctrl[3:0]);
        ratio = (div == 0) ? 128 : (div == 1) ? 32 : 1;
        hold  = rst || (div > 2);
        base  = 1'b0;
        e_tick = 1'b0;
        e_sec  = 1'b0;
        if (hold) begin
            r_cnt = 0;
            b_cnt = 0;
        end else if (ref_en) begin
            r_cnt++;
            if (r_cnt % ratio == 0) begin
                base = 1'b1;
                b_cnt++;
            end
        end
        if (base) begin
            e_tick = (rate != 0) && (b_cnt % (1 << (rate - 1)) == 0);
            e_sec  = (b_cnt % 32768 == 0);
        end
        if (hold || !sqw_en || rate == 0) e_sq = 1'b0;
        else if (e_tick)                  e_sq = ~e_sq;
        @(negedge clk);
        chk("periodic_tick", periodic_tick, e_tick);
        chk("sq_wave", sq_wave, e_sq);
        chk("sec_tick", sec_tick, e_sec);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic finish_up();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            finish_up();
        end
    end

    initial begin
        rst = 1'b1; ref_en = 1'b1; ctrl = 8'h21; sqw_en = 1'b1;
        @(negedge clk);
        tag = "R10 reset";
        run(5);
        rst = 1'b0;

        tag = "R2 hold code 6";
        ctrl = 8'h61;
        run(10);

        // Slow reference, every cycle a base tick; sweep all rates without a hold.
        tag = "R4 R5 R6 R7 rate sweep";
        for (int code = 1; code < 16; code++) begin
            ctrl = 8'h20 | 8'(code);
            run(2 * (1 << (code - 1)) + 4);
        end

        tag = "R3 rate none";
        ctrl = 8'h20;
        run(100);

        tag = "R5 square disabled";
        ctrl = 8'h22; sqw_en = 1'b0;
        run(60);
        sqw_en = 1'b1;
        run(40);

        tag = "R2 hold code 7";
        ctrl = 8'h71;
        run(8);
        tag = "R1 fast reference";
        ctrl = 8'h01;
        run(600);

        tag = "R2 hold code 3";
        ctrl = 8'h32;
        run(8);
        tag = "R1 R8 middle reference sparse";
        ctrl = 8'h12;
        for (int i = 0; i < 900; i++) begin
            ref_en = (i % 3 == 0);
            step();
        end
        ref_en = 1'b1;

        tag = "R2 hold code 4";
        ctrl = 8'h41;
        run(5);
        tag = "R9 spare bit set";
        ctrl = 8'hA3;
        run(200);

        tag = "R2 hold code 5";
        ctrl = 8'h51;
        run(5);
        tag = "R7 second after release";
        ctrl = 8'h2F;
        run(33000);

        tag = "R10 mid-run reset";
        ctrl = 8'h21;
        run(7);
        rst = 1'b1;
        run(3);
        rst = 1'b0;
        run(20);

        done = 1'b1;
        finish_up();
    end

endmodule